// File: doc/BRIEF.md
# Flash Initialization Command Sequencer

This block runs a short set-up sequence on a serial flash device before the controller around it starts execute-in-place reads. A single 32-bit configuration word sets up to three command bytes, how many of them go out, the lane width they use, and whether the sequence ends with a wait for the device to finish its internal work. A one-cycle start pulse launches the sequence. The block then drives chip select, the serial clock and the data lanes itself, and signals the end with a one-cycle done pulse.

Each command byte is a separate chip-select transaction. The serial clock runs at a fixed ratio of the system clock. When the status wait is enabled, the block opens one further transaction and sends the read-status opcode. It then keeps reading status bytes inside that same transaction until the device reports ready. A configuration that asks for the reserved lane width sends nothing and ends at once with an error indication.

Top module: `flash_init_seq`

## Requirements
- R1: Command bytes go out in fixed order: the byte in cfg_word[15:8] first, then cfg_word[23:16], then cfg_word[31:24].
- R2: cfg_word[3:2] sets how many commands are sent: 0 sends none, 1 sends the first, 2 sends the first two, 3 sends all three.
- R3: cfg_word[1:0] sets the lane width for every command: 0 is one lane on io_out[0] (8 serial clocks), 1 is two lanes on io_out[1:0] (4 clocks), 2 is four lanes on io_out[3:0] (2 clocks). Bits go out most significant first. io_oe enables exactly the lanes in use while a byte is sent.
- R4: Lane width code 3 is reserved. With it, no transaction is made, and err is high in the same cycle as done.
- R5: When cfg_word[4] is 1, a final transaction follows the commands. It sends opcode 0x05 on one lane, then reads status bytes on io_in[1], most significant bit first, with io_oe all zero. It stops after the first byte whose bit 0 is clear. Chip select stays low for the whole transaction.
- R6: When cfg_word[4] is 0, the sequence ends after the last command and makes no status transaction.
- R7: Each command is its own transaction. Between two transactions, cs_n is high for at least two system clocks.
- R8: sck stays low whenever cs_n is high. Data lanes change only on falling sck edges, so they are stable when sck rises.
- R9: done is a single-cycle pulse, given once per sequence, also when nothing is sent. busy is high in the cycle after an accepted start and stays high until done.
- R10: A start pulse that arrives while busy is high is ignored. The running sequence and its configuration are not changed.
- R11: After reset: cs_n=1, sck=0, io_oe=0, busy=0, done=0 and err=0. An all-zero configuration produces done with no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to run the sequence |
| cfg_word | input | 32 | Packed configuration, captured when a start is accepted |
| io_in | input | 4 | Data lanes from the flash; status is read on bit 1 |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idles low |
| io_out | output | 4 | Data lanes to the flash |
| io_oe | output | 4 | Per-lane output enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Reserved lane width was requested; valid with done |

## Verification
The sweep covers every combination of lane width, command count and status-wait enable. Each combination uses its own command bytes, so a swapped or repeated byte shows up as a wrong value. The number of clocks per byte tells the three lane widths apart, and the enabled-lane mask tells the used lanes from the idle ones. The device model reports busy for zero, one or two reads before it reports ready, and each status transaction is checked for its total length. This shows that the block keeps polling until it sees bit 0 clear, and stops there. A second start, carrying a different configuration, is sent in the middle of every non-empty sequence. The extra transactions or the second done it would cause if accepted show whether it was ignored.

// File: rtl/flash_init_pkg.sv
package flash_init_pkg;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_X4  = 2'd2,
    LANE_RSV = 2'd3
  } lane_e;

  typedef struct packed {
    logic [7:0] cmd_c;
    logic [7:0] cmd_b;
    logic [7:0] cmd_a;
    logic [2:0] spare;
    logic       poll;
    logic [1:0] cnt;
    lane_e      lane;
  } cfg_t;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_SETUP   = 3'd1,
    S_XFER    = 3'd2,
    S_GAP     = 3'd3,
    S_POLL_OP = 3'd4,
    S_POLL_RD = 3'd5,
    S_FIN     = 3'd6
  } seq_state_e;

  localparam logic [7:0] STATUS_OPCODE = 8'h05;

endpackage

// File: rtl/fis_shift.sv
module fis_shift
  import flash_init_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  lane_e      lanes,
  input  logic       drive,
  input  logic       sdi,
  output logic       sck,
  output logic [3:0] sdo,
  output logic [3:0] sdo_en,
  output logic       fin,
  output logic [7:0] rx_byte
);

  localparam int HCW = $clog2(HALF_DIV + 1);
  localparam logic [HCW-1:0] HC_TOP = HCW'(HALF_DIV - 1);

  logic [7:0]     sr_q, sr_d;
  logic [7:0]     rx_q, rx_d;
  lane_e          lanes_q, lanes_d;
  logic           drv_q, drv_d;
  logic [HCW-1:0] hc_q, hc_d;
  logic [3:0]     left_q, left_d;
  logic           sck_q, sck_d;
  logic           act_q, act_d;
  logic           fin_q, fin_d;

  logic [2:0] step;
  logic [3:0] clocks_per_byte;
  logic [3:0] lane_mask;

  always_comb begin
    unique case (lanes_q)
      LANE_X2: begin step = 3'd2; lane_mask = 4'b0011; end
      LANE_X4: begin step = 3'd4; lane_mask = 4'b1111; end
      default: begin step = 3'd1; lane_mask = 4'b0001; end
    endcase
  end

  always_comb begin
    unique case (lanes)
      LANE_X2: clocks_per_byte = 4'd4;
      LANE_X4: clocks_per_byte = 4'd2;
      default: clocks_per_byte = 4'd8;
    endcase
  end

  always_comb begin
    sr_d    = sr_q;
    rx_d    = rx_q;
    lanes_d = lanes_q;
    drv_d   = drv_q;
    hc_d    = hc_q;
    left_d  = left_q;
    sck_d   = sck_q;
    act_d   = act_q;
    fin_d   = 1'b0;
    if (go) begin
      sr_d    = tx_byte;
      rx_d    = 8'h00;
      lanes_d = lanes;
      drv_d   = drive;
      hc_d    = HC_TOP;
      left_d  = clocks_per_byte;
      sck_d   = 1'b0;
      act_d   = 1'b1;
    end else if (act_q) begin
      if (hc_q == '0) begin
        hc_d  = HC_TOP;
        sck_d = ~sck_q;
        if (!sck_q) begin
          rx_d   = {rx_q[6:0], sdi};
          left_d = left_q - 4'd1;
        end else if (left_q == 4'd0) begin
          act_d = 1'b0;
          fin_d = 1'b1;
        end else begin
          sr_d = sr_q << step;
        end
      end else begin
        hc_d = hc_q - HCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      rx_q    <= '0;
      lanes_q <= LANE_X1;
      drv_q   <= 1'b0;
      hc_q    <= '0;
      left_q  <= '0;
      sck_q   <= 1'b0;
      act_q   <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      rx_q    <= rx_d;
      lanes_q <= lanes_d;
      drv_q   <= drv_d;
      hc_q    <= hc_d;
      left_q  <= left_d;
      sck_q   <= sck_d;
      act_q   <= act_d;
      fin_q   <= fin_d;
    end
  end

  always_comb begin
    unique case (lanes_q)
      LANE_X2: sdo = {2'b00, sr_q[7:6]};
      LANE_X4: sdo = sr_q[7:4];
      default: sdo = {3'b000, sr_q[7]};
    endcase
  end

  assign sdo_en  = (act_q && drv_q) ? lane_mask : 4'b0000;
  assign sck     = sck_q;
  assign fin     = fin_q;
  assign rx_byte = rx_q;

  // R8: lanes hold their value across every rising serial clock edge
  p_mode0_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $stable(sdo));

  // R8: an idle shifter leaves the clock low and drives no lane
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (!sck_q && sdo_en == 4'b0000));

  // R3: a byte ends only after a falling edge, with the shifter idle
  p_fin_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (!sck_q && !act_q && $past(sck_q)));

endmodule

// File: rtl/fis_ctrl.sv
module fis_ctrl
  import flash_init_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] cfg_word,
  input  logic        fin,
  input  logic [7:0]  rx_byte,
  output logic        go,
  output logic [7:0]  tx_byte,
  output lane_e       lanes,
  output logic        drive,
  output logic        cs_n,
  output logic        busy,
  output logic        done,
  output logic        err
);

  localparam int GCW = $clog2(GAP_CYC + 1);
  localparam logic [GCW-1:0] GAP_LAST = GCW'(GAP_CYC - 1);

  seq_state_e     st_q, st_d;
  cfg_t           cfg_q, cfg_d;
  cfg_t           cfg_in;
  logic [1:0]     idx_q, idx_d;
  logic           ph_q, ph_d;
  logic [GCW-1:0] gap_q, gap_d;
  logic           more_cmds;
  logic [7:0]     cmd_sel;

  assign cfg_in    = cfg_t'(cfg_word);
  assign more_cmds = ({1'b0, idx_q} + 3'd1) < {1'b0, cfg_q.cnt};

  always_comb begin
    st_d  = st_q;
    cfg_d = cfg_q;
    idx_d = idx_q;
    ph_d  = ph_q;
    gap_d = gap_q;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          cfg_d = cfg_in;
          idx_d = 2'd0;
          ph_d  = 1'b0;
          if (cfg_in.lane == LANE_RSV) begin
            st_d = S_FIN;
          end else if (cfg_in.cnt != 2'd0) begin
            st_d = S_SETUP;
          end else if (cfg_in.poll) begin
            ph_d = 1'b1;
            st_d = S_SETUP;
          end else begin
            st_d = S_FIN;
          end
        end
      end
      S_SETUP: st_d = ph_q ? S_POLL_OP : S_XFER;
      S_XFER: begin
        if (fin) begin
          gap_d = '0;
          if (more_cmds) begin
            idx_d = idx_q + 2'd1;
            st_d  = S_GAP;
          end else if (cfg_q.poll) begin
            ph_d = 1'b1;
            st_d = S_GAP;
          end else begin
            st_d = S_FIN;
          end
        end
      end
      S_GAP: begin
        if (gap_q == GAP_LAST) st_d = S_SETUP;
        else                   gap_d = gap_q + GCW'(1);
      end
      S_POLL_OP: if (fin) st_d = S_POLL_RD;
      S_POLL_RD: if (fin && !rx_byte[0]) st_d = S_FIN;
      S_FIN:     st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cfg_q <= '0;
      idx_q <= '0;
      ph_q  <= 1'b0;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      cfg_q <= cfg_d;
      idx_q <= idx_d;
      ph_q  <= ph_d;
      gap_q <= gap_d;
    end
  end

  always_comb begin
    unique case (idx_q)
      2'd0:    cmd_sel = cfg_q.cmd_a;
      2'd1:    cmd_sel = cfg_q.cmd_b;
      default: cmd_sel = cfg_q.cmd_c;
    endcase
  end

  assign go = (st_q == S_SETUP)
            | ((st_q == S_POLL_OP) && fin)
            | ((st_q == S_POLL_RD) && fin && rx_byte[0]);

  assign tx_byte = ph_q ? ((st_q == S_SETUP) ? STATUS_OPCODE : 8'h00) : cmd_sel;
  assign lanes   = ph_q ? LANE_X1 : cfg_q.lane;
  assign drive   = (st_q == S_SETUP);
  assign cs_n    = !((st_q == S_SETUP) || (st_q == S_XFER) ||
                     (st_q == S_POLL_OP) || (st_q == S_POLL_RD));
  assign busy    = (st_q != S_IDLE);
  assign done    = (st_q == S_FIN);
  assign err     = done && (cfg_q.lane == LANE_RSV);

  // R9: done never lasts two cycles
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: an error is only reported together with done
  p_err_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10: a start during a run leaves the captured configuration alone
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cfg_q));

  // R7: chip select stays high for at least two cycles once released
  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  // R2: a command transfer never passes the programmed count
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_XFER) |-> ({1'b0, idx_q} < {1'b0, cfg_q.cnt}));

endmodule

// File: rtl/flash_init_seq.sv
module flash_init_seq
  import flash_init_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] cfg_word,
  input  logic [3:0]  io_in,
  output logic        cs_n,
  output logic        sck,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  output logic        busy,
  output logic        done,
  output logic        err
);

  logic       rst_meta, rst_sync;
  logic       go, drive, fin;
  logic [7:0] tx_byte, rx_byte;
  lane_e      lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  fis_ctrl #(.GAP_CYC(GAP_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync),
    .start    (start),
    .cfg_word (cfg_word),
    .fin      (fin),
    .rx_byte  (rx_byte),
    .go       (go),
    .tx_byte  (tx_byte),
    .lanes    (lanes),
    .drive    (drive),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done),
    .err      (err)
  );

  fis_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync),
    .go      (go),
    .tx_byte (tx_byte),
    .lanes   (lanes),
    .drive   (drive),
    .sdi     (io_in[1]),
    .sck     (sck),
    .sdo     (io_out),
    .sdo_en  (io_oe),
    .fin     (fin),
    .rx_byte (rx_byte)
  );

  // R8: the serial clock rests low outside a transaction
  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    cs_n |-> !sck);

  // R5: no lane is driven while chip select is high
  p_no_drive_idle_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    cs_n |-> (io_oe == 4'b0000));

endmodule

// File: tb/flash_init_seq_test.sv
module flash_init_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [3:0]  io_in = '0;
  logic        cs_n, sck, busy, done, err;
  logic [3:0]  io_out, io_oe;

  always #10 clk = ~clk;

  flash_init_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word), .io_in(io_in),
    .cs_n(cs_n), .sck(sck), .io_out(io_out), .io_oe(io_oe),
    .busy(busy), .done(done), .err(err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int exp_cmds = 0;
  int lw = 1;
  int br = 0;
  int ntr = 0;
  int rises = 0;
  logic [7:0] sh = '0;
  logic [7:0] tr_byte [0:7];
  int tr_rises [0:7];
  int oe_bad = 0;
  int idle_bad = 0;
  int gap_min = 1000;
  int hi_run = 0;
  bit seen_tr = 0;
  logic prev_cs = 1'b1;
  int done_cnt = 0;
  int err_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] mask_of(input int w);
    if (w == 1) return 4'b0001;
    if (w == 2) return 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [7:0] stat_of(input int n);
    return (n < br) ? 8'h5B : 8'h5A;
  endfunction

  always @(negedge cs_n) begin
    ntr++;
    rises = 0;
    sh = '0;
  end

  always @(posedge sck) begin
    int w;
    logic [3:0] m;
    w = (ntr - 1 < exp_cmds) ? lw : 1;
    if (ntr - 1 < exp_cmds) m = mask_of(lw);
    else m = (rises < 8) ? 4'b0001 : 4'b0000;
    if (io_oe !== m) oe_bad++;
    if (rises < 8 / w) begin
      if (w == 1)      sh = {sh[6:0], io_out[0]};
      else if (w == 2) sh = {sh[5:0], io_out[1:0]};
      else             sh = {sh[3:0], io_out[3:0]};
    end
    rises++;
    if (ntr >= 1 && ntr <= 8) begin
      if (rises == 8 / w) tr_byte[ntr-1] = sh;
      tr_rises[ntr-1] = rises;
    end
  end

  always @(negedge sck) begin
    if (!cs_n && (ntr - 1 >= exp_cmds) && rises >= 8) begin
      int j;
      logic [7:0] s;
      j = rises - 8;
      s = stat_of(j / 8);
      io_in[1] = s[7 - (j % 8)];
    end
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (err) err_cnt++;
    if (cs_n && sck) idle_bad++;
    if (!cs_n) begin
      if (prev_cs && seen_tr && hi_run < gap_min) gap_min = hi_run;
      hi_run = 0;
      seen_tr = 1;
    end else begin
      hi_run++;
    end
    prev_cs = cs_n;
  end

  task automatic run_case(input int lane, input int cnt, input int poll, input int run);
    logic [7:0] c [0:2];
    int exp_poll;
    int exp_tr;
    int w;
    c[0] = 8'(8'h5C + run * 3);
    c[1] = 8'(8'hC1 ^ run);
    c[2] = 8'(8'h96 + run * 11);
    exp_cmds = (lane == 3) ? 0 : cnt;
    exp_poll = (lane != 3 && poll == 1) ? 1 : 0;
    exp_tr   = exp_cmds + exp_poll;
    lw = (lane == 0) ? 1 : (lane == 1) ? 2 : 4;
    br = (lane + cnt + poll) % 3;
    ntr = 0; oe_bad = 0; idle_bad = 0; gap_min = 1000; hi_run = 0;
    seen_tr = 0; done_cnt = 0; err_cnt = 0;
    for (int i = 0; i < 8; i++) begin tr_byte[i] = '0; tr_rises[i] = 0; end
    @(negedge clk);
    cfg_word = {c[2], c[1], c[0], 3'b000, 1'(poll), 2'(cnt), 2'(lane)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", int'(busy), 1);
    if (exp_tr > 0) begin
      repeat (5) @(negedge clk);
      cfg_word = {8'hEE, 8'hDD, 8'hCC, 3'b000, 1'b1, 2'd3, 2'd2};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 20000) begin
      @(negedge clk);
      w++;
    end
    repeat (40) @(negedge clk);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(err_cnt == ((lane == 3) ? 1 : 0), "R4", "err pulses", err_cnt, (lane == 3) ? 1 : 0);
    if (lane == 3) chk(ntr == 0, "R4", "transactions reserved", ntr, 0);
    else if (poll == 0) chk(ntr == exp_tr, "R6", "transactions no poll", ntr, exp_tr);
    else chk(ntr == exp_tr, "R2", "transactions", ntr, exp_tr);
    if (exp_tr > 0) chk(ntr == exp_tr, "R10", "transactions after ignored start", ntr, exp_tr);
    for (int i = 0; i < exp_cmds; i++) begin
      chk(tr_byte[i] == c[i], "R1", "command byte", int'(tr_byte[i]), int'(c[i]));
      chk(tr_rises[i] == 8 / lw, "R3", "clocks per command", tr_rises[i], 8 / lw);
    end
    if (exp_poll == 1) begin
      chk(tr_byte[exp_cmds] == 8'h05, "R5", "status opcode",
          int'(tr_byte[exp_cmds]), 8'h05);
      chk(tr_rises[exp_cmds] == 8 + 8 * (br + 1), "R5", "poll clocks",
          tr_rises[exp_cmds], 8 + 8 * (br + 1));
    end
    chk(oe_bad == 0, "R3", "lane enable mismatches", oe_bad, 0);
    chk(idle_bad == 0, "R8", "sck high with cs high", idle_bad, 0);
    if (ntr > 1) chk(gap_min >= 2, "R7", "cs high gap", gap_min, 2);
    if (lane == 0 && cnt == 0 && poll == 0)
      chk(ntr == 0 && done_cnt == 1, "R11", "all-zero config", ntr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n === 1'b1, "R11", "reset cs_n", int'(cs_n), 1);
    chk(sck === 1'b0, "R11", "reset sck", int'(sck), 0);
    chk(io_oe === 4'b0000, "R11", "reset io_oe", int'(io_oe), 0);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R11", "reset flags",
        int'({busy, done, err}), 0);
    for (int lane = 0; lane < 4; lane++)
      for (int cnt = 0; cnt < 4; cnt++)
        for (int poll = 0; poll < 2; poll++)
          run_case(lane, cnt, poll, lane * 8 + cnt * 2 + poll);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule